// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It opens and closes the sample switch, derives a SAR clock from the system clock through a programmable divider, and runs a binary search over the DAC trial code against a one-bit comparator decision. The converter's analog parts stay outside. The comparator reaches the block as a single digital input that reports whether the held input is at or above the present trial code.

Conversions start from an asynchronous start pin. A mode input selects one of two tracking policies:

- **Mode 0:** the switch tracks while the pin is low, and a rising edge starts the conversion.
- **Mode 1:** the switch tracks whenever the block is idle, and it stays closed for three more SAR clocks after the rising edge.

A minimum tracking count, in system clocks, keeps the sampling capacitor connected long enough before any conversion begins.

The state machine has four states:

- **S_TRACK:** idle and tracking.
- **S_EXTEND:** the three-SAR-clock extension in mode 1.
- **S_PEND:** the start has been accepted, but tracking continues until the minimum count is met.
- **S_CONV:** bit decisions are under way.

The transitions are:

- S_TRACK→S_CONV: a start edge in mode 0 when the minimum is already met.
- S_TRACK→S_PEND: a start edge in mode 0 when the minimum is not yet met.
- S_TRACK→S_EXTEND: a start edge in mode 1.
- S_EXTEND→S_CONV or S_EXTEND→S_PEND: on the third SAR tick, depending on the minimum.
- S_PEND→S_CONV: once the minimum is met.
- S_CONV→S_TRACK: on the tenth SAR tick.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, done_o and result_o are 0, dac_code_o is 0, the machine is in S_TRACK, and in mode 0 with the pin low trk_sw_o is 1 (1 means the switch is closed).
- R2: In mode 0, the idle switch follows the synchronized pin inverted. A rising pin edge that is set up before clock edge E0 opens the switch after edge E0+2, and from then the trial code is 10'h200 when the minimum tracking is met.
- R3: In mode 1, the switch is closed whenever no conversion runs. After a start edge it stays closed for exactly 3 SAR clocks before converting.
- R4: Bits are decided from MSB to LSB. A bit is kept when cmp_above_i is 1 while its trial code is presented, so with an ideal comparator result_o equals the input code.
- R5: A conversion begins only after trk_sw_o has been 1 for at least min_trk_i consecutive cycles. Otherwise the machine holds the switch closed in S_PEND until the count is met.
- R6: The SAR clock period is clk_div_i system clocks, with 0 treated as 1. When lowpwr_i is 1, values below 2 are treated as 2.
- R7: A conversion takes 10 SAR clocks. With period d and the minimum met, done_o rises after edge E0+2+10d in mode 0 and after edge E0+2+13d in mode 1.
- R8: done_o is a one-cycle pulse. result_o changes only in the cycle in which done_o is 1.
- R9: A start edge that arrives while in S_EXTEND, S_PEND or S_CONV is ignored. Exactly one done pulse results, and the latency is unchanged.
- R10: The pin passes through two flops before edge detection. A pin held high after a conversion starts nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_start_i | input | 1 | Asynchronous conversion-start pin |
| trk_mode_i | input | 1 | Tracking policy: 0 tracks while the pin is low, 1 tracks while idle plus a 3-SAR-clock extension |
| clk_div_i | input | DIV_W | SAR clock divide ratio |
| lowpwr_i | input | 1 | Low-power memory option; clamps the divide ratio to at least 2 |
| min_trk_i | input | TRK_W | Minimum tracking time in system clocks |
| cmp_above_i | input | 1 | Comparator: held input at or above the trial code |
| trk_sw_o | output | 1 | Sample switch, 1 = closed (tracking) |
| dac_code_o | output | RES_W | DAC trial code, 0 outside a conversion |
| result_o | output | RES_W | Last conversion result |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong state, a lost extension count or a mis-sized divider shows first as a done pulse that arrives early or late by whole SAR periods. The bench therefore measures the done cycle exactly against 3+10d or 3+13d. A slip in the bit index or the accumulator corrupts result_o at that same done cycle, and a switch stuck in the wrong position shows on trk_sw_o within three cycles of the start edge. A stale edge detector or a missing ignore rule shows up as a second done pulse in the window that follows.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        S_TRACK  = 2'd0,
        S_EXTEND = 2'd1,
        S_PEND   = 2'd2,
        S_CONV   = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             lowpwr_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        eff = div_i;
        if (eff == '0)
            eff = DIV_W'(1);
        if (lowpwr_i && eff < DIV_W'(2))
            eff = DIV_W'(2);
    end

    assign tick_o = run_i && (cnt_q == eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R6: with the low-power clamp, two ticks are never adjacent
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lowpwr_i) |=> !tick_o);
endmodule

// File: rtl/sar_trk_timer.sv
module sar_trk_timer #(
    parameter int TRK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             closed_i,
    input  logic [TRK_W-1:0] min_i,
    output logic             ready_o
);
    logic [TRK_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!closed_i)
            cnt_q <= '0;
        else if (cnt_q != '1)
            cnt_q <= cnt_q + TRK_W'(1);
    end

    assign ready_o = (cnt_q >= min_i);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] final_o,
    output logic             last_o
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] MSB_ONLY = RES_W'(1) << (RES_W - 1);

    logic [RES_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] bit_mask;

    assign bit_mask = RES_W'(1) << idx_q;
    assign trial_o  = acc_q | bit_mask;
    assign final_o  = cmp_i ? (acc_q | bit_mask) : acc_q;
    assign last_o   = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= TOP_IDX;
        end else if (load_i) begin
            acc_q <= '0;
            idx_q <= TOP_IDX;
        end else if (step_i) begin
            acc_q <= final_o;
            if (idx_q != '0)
                idx_q <= idx_q - IDX_W'(1);
        end
    end

    // R4: the first trial after a load is the MSB alone
    p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (trial_o == MSB_ONLY));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int DIV_W    = 4,
    parameter int TRK_W    = 8,
    parameter int EXT_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv_start_i,
    input  logic             trk_mode_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic             lowpwr_i,
    input  logic [TRK_W-1:0] min_trk_i,
    input  logic             cmp_above_i,
    output logic             trk_sw_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    localparam int EXT_W = $clog2(EXT_CLKS + 1);
    localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_CLKS - 1);

    sar_state_e       state_q, state_d;
    logic             start_lvl, start_rise;
    logic             sar_tick, trk_ready;
    logic             div_run, conv_load, conv_step;
    logic             eng_last;
    logic [RES_W-1:0] eng_trial, eng_final;
    logic [EXT_W-1:0] ext_q;
    logic [RES_W-1:0] result_q;
    logic             done_q;

    sar_start_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (cnv_start_i),
        .level_o (start_lvl),
        .rise_o  (start_rise)
    );

    sar_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (div_run),
        .div_i    (clk_div_i),
        .lowpwr_i (lowpwr_i),
        .tick_o   (sar_tick)
    );

    sar_trk_timer #(.TRK_W(TRK_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .closed_i (trk_sw_o),
        .min_i    (min_trk_i),
        .ready_o  (trk_ready)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (conv_load),
        .step_i  (conv_step),
        .cmp_i   (cmp_above_i),
        .trial_o (eng_trial),
        .final_o (eng_final),
        .last_o  (eng_last)
    );

    assign div_run   = (state_q == S_EXTEND) || (state_q == S_CONV);
    assign conv_load = (state_d == S_CONV) && (state_q != S_CONV);
    assign conv_step = (state_q == S_CONV) && sar_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_TRACK;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_TRACK: begin
                if (start_rise) begin
                    if (trk_mode_i)
                        state_d = S_EXTEND;
                    else if (trk_ready)
                        state_d = S_CONV;
                    else
                        state_d = S_PEND;
                end
            end
            S_EXTEND: begin
                if (sar_tick && ext_q == EXT_LAST)
                    state_d = trk_ready ? S_CONV : S_PEND;
            end
            S_PEND: begin
                if (trk_ready)
                    state_d = S_CONV;
            end
            S_CONV: begin
                if (sar_tick && eng_last)
                    state_d = S_TRACK;
            end
            default: state_d = S_TRACK;
        endcase
    end

    // extension tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ext_q <= '0;
        else if (state_q != S_EXTEND)
            ext_q <= '0;
        else if (sar_tick)
            ext_q <= ext_q + EXT_W'(1);
    end

    // outputs
    always_comb begin
        trk_sw_o   = 1'b0;
        dac_code_o = '0;
        unique case (state_q)
            S_TRACK:  trk_sw_o = trk_mode_i ? 1'b1 : ~start_lvl;
            S_EXTEND: trk_sw_o = 1'b1;
            S_PEND:   trk_sw_o = 1'b1;
            S_CONV:   dac_code_o = eng_trial;
            default:  trk_sw_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else if (conv_step && eng_last) begin
            result_q <= eng_final;
            done_q   <= 1'b1;
        end else begin
            done_q   <= 1'b0;
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

    // R8: the done pulse lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the result moves only with done
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R5: entry into conversion follows a met tracking minimum
    p_min_trk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_CONV) |-> $past(trk_ready));

    // R9: a start edge during a conversion does not disturb it
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV && start_rise) |=> (state_q == S_CONV || done_o));
endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] div = 4'd1;
    logic       lp = 1'b0;
    logic [7:0] min_trk = 8'd8;
    logic [9:0] vin = '0;
    logic       cmp;
    logic       trk_sw;
    logic [9:0] dac;
    logic [9:0] result;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign cmp = (vin >= dac);

    sar_conv_seq i_sar_conv_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start_i (pin),
        .trk_mode_i  (mode),
        .clk_div_i   (div),
        .lowpwr_i    (lp),
        .min_trk_i   (min_trk),
        .cmp_above_i (cmp),
        .trk_sw_o    (trk_sw),
        .dac_code_o  (dac),
        .result_o    (result),
        .done_o      (done)
    );

    // fields: [15] mode, [14] lowpwr, [13:10] divider, [9:0] input code
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b0, 4'd1, 10'h000},
        {1'b0, 1'b0, 4'd0, 10'h3FF},
        {1'b0, 1'b0, 4'd3, 10'h155},
        {1'b0, 1'b1, 4'd0, 10'h2AA},
        {1'b1, 1'b1, 4'd1, 10'h200},
        {1'b1, 1'b0, 4'd2, 10'h1FF},
        {1'b1, 1'b0, 4'd5, 10'h001},
        {1'b0, 1'b1, 4'd4, 10'h3FE}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_div(input logic [3:0] d, input logic l);
        int e = (d == 0) ? 1 : int'(d);
        if (l && e < 2) e = 2;
        return e;
    endfunction

    task automatic run_vec(input logic m, input logic l, input logic [3:0] d, input logic [9:0] v);
        int cnt = 0;
        bit got = 0;
        int exp_lat;
        mode = m; lp = l; div = d; vin = v; pin = 1'b0;
        exp_lat = 3 + (m ? 13 : 10) * eff_div(d, l);
        repeat (40) @(negedge clk);
        pin = 1'b1;
        while (!got && cnt < 3000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) begin
                if (!m) begin
                    chk(trk_sw == 1'b0, "R2 switch open at start", int'(trk_sw), 0);
                    chk(dac == 10'h200, "R2 first trial code", int'(dac), 'h200);
                end else begin
                    chk(trk_sw == 1'b1, "R3 extension keeps tracking", int'(trk_sw), 1);
                end
            end
            if (done) got = 1;
        end
        chk(cnt == exp_lat, "R7 R6 done latency", cnt, exp_lat);
        chk(result == v, "R4 result code", int'(result), int'(v));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        chk(result == v, "R8 result held", int'(result), int'(v));
        pin = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(result == 10'h0, "R1 result after reset", int'(result), 0);
        chk(dac == 10'h0, "R1 dac after reset", int'(dac), 0);
        chk(trk_sw == 1'b1, "R1 switch closed after reset", int'(trk_sw), 1);

        foreach (VEC[i])
            run_vec(VEC[i][15], VEC[i][14], VEC[i][13:10], VEC[i][9:0]);

        // R9: a second start edge during the conversion is ignored
        mode = 1'b0; lp = 1'b0; div = 4'd2; vin = 10'h123; min_trk = 8'd8;
        repeat (40) @(negedge clk);
        pin = 1'b1;
        cnt = 0; seen = 0;
        while (seen == 0 && cnt < 3000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 8)  pin = 1'b0;
            if (cnt == 12) pin = 1'b1;
            if (done) seen = 1;
        end
        chk(cnt == 23, "R9 latency with ignored start", cnt, 23);
        chk(result == 10'h123, "R9 result with ignored start", int'(result), 'h123);
        // R10: pin held high, no second conversion
        seen = 0;
        repeat (80) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(seen == 0, "R10 no retrigger while high", seen, 0);
        chk(trk_sw == 1'b0, "R10 mode0 switch open while pin high", int'(trk_sw), 0);

        // R5: short tracking forces the pending state
        div = 4'd1; min_trk = 8'd40; vin = 10'h2C3;
        pin = 1'b0;
        repeat (5) @(negedge clk);
        pin = 1'b1;
        cnt = 0; seen = 0;
        while (seen == 0 && cnt < 3000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 10)
                chk(trk_sw == 1'b1, "R5 pending keeps switch closed", int'(trk_sw), 1);
            if (done) seen = 1;
        end
        chk(cnt == 54, "R5 latency after pending", cnt, 54);
        chk(result == 10'h2C3, "R5 result after pending", int'(result), 'h2C3);
        pin = 1'b0;
        repeat (5) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule